// File: doc/BRIEF.md
# Four-by-Five Bus Crossbar with Per-Port Arbitration

This block joins four bus masters (instruction fetch, data access, DMA and external bus) to five bus slaves (flash, external bus, SRAM and two peripheral bridges). Every master and every slave uses the same beat handshake. A beat carries a valid/ready pair, an address, a write flag, write data and a flag that marks the final beat of a transfer. Read data comes back in the cycle the beat is accepted. The upper four address bits pick the target slave. Masters that talk to different slaves pass straight through, side by side.

Each slave port has its own arbiter. When several masters ask for the same slave, one is granted and the others see ready held low. The winner keeps the port until the slave accepts its final beat. By default the arbiter is round-robin and starts its search after the master it granted most recently. A mode input switches every arbiter to fixed priority, with a 2-bit level for each master.

Top module: `xbar_switch`

## Requirements
- R1: Address bits [31:28] choose the slave: 0x0 gives flash (slave 0), 0x2 gives external bus (slave 1), 0x4 gives SRAM (slave 2), 0xC gives bridge A (slave 3) and 0xF gives bridge B (slave 4). Any master can reach any of them, and the slave sees that master's address, write flag and data.
- R2: A valid beat to any other address value is accepted in the same cycle with `m_err` high, and no slave sees `s_valid` for it.
- R3: Masters that target different slaves are all passed through in the same cycle.
- R4: A slave port grants at most one master at a time. Any other master requesting that slave sees `m_ready` low.
- R5: A granted master keeps the slave until a beat with `m_last` high is accepted (valid and `s_ready` both high). The owner is kept while `s_ready` is low and while other masters are requesting.
- R6: With `cfg_fixed` low, a new grant goes to the first requesting master found in the order last-granted ID + 1, + 2, and so on, wrapping modulo 4. After reset the last-granted ID is 3, so master 0 wins the first contention.
- R7: With `cfg_fixed` high, the requester with the largest priority field `cfg_prio[2m+1:2m]` wins. On a tie, the lower master ID wins.
- R8: On slaves 3 and 4, bits [63:32] of `s_wdata` are driven zero, and bits [63:32] of the returned `m_rdata` are zero.
- R9: A request to a slave that has no owner reaches `s_valid` in the same cycle. The data the slave returns reaches `m_rdata` of the granted master in that same cycle.
- R10: After reset, with no master valid, every `s_valid` and every `m_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_fixed | input | 1 | 1 = fixed priority, 0 = round-robin |
| cfg_prio | input | 8 | 2-bit priority per master, master m in bits [2m+1:2m] |
| m_valid | input | 4 | Beat valid per master |
| m_ready | output | 4 | Beat accepted per master |
| m_addr | input | 128 | 32-bit address per master |
| m_write | input | 4 | Write flag per master |
| m_wdata | input | 256 | 64-bit write data per master |
| m_last | input | 4 | Final beat of the transfer |
| m_rdata | output | 256 | 64-bit read data per master |
| m_err | output | 4 | Unmapped-address response |
| s_valid | output | 5 | Beat valid per slave |
| s_ready | input | 5 | Beat accepted by slave |
| s_addr | output | 160 | Address per slave |
| s_write | output | 5 | Write flag per slave |
| s_wdata | output | 320 | Write data per slave |
| s_last | output | 5 | Final-beat flag per slave |
| s_rdata | input | 320 | Read data per slave |

## Verification
The hardest case to reach is a locked port: a second master asks for the same slave while the owner is in the middle of a multi-beat transfer and the slave is stalling. The bench gets there in steps. One master opens a burst alone. A rival joins on the next cycle. The slave then drops ready for a cycle before the final beat. Only after that does the bench check that the rival takes the port. Priority order is checked in a separate way. All four masters hold requests to one slave across several cycles, so the rotation or fixed ranking shows up one grant per cycle.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  localparam int XB_REGION_W = 4;

  typedef struct packed {
    logic       hit;
    logic [2:0] idx;
  } xb_route_t;

  // upper-address region to slave index
  function automatic xb_route_t xb_decode(input logic [XB_REGION_W-1:0] region);
    xb_route_t r;
    r.hit = 1'b1;
    r.idx = 3'd0;
    case (region)
      4'h0: r.idx = 3'd0;
      4'h2: r.idx = 3'd1;
      4'h4: r.idx = 3'd2;
      4'hC: r.idx = 3'd3;
      4'hF: r.idx = 3'd4;
      default: r.hit = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/xbar_addr_dec.sv
module xbar_addr_dec
  import xbar_pkg::*;
#(
  parameter int NS = 5
) (
  input  logic [XB_REGION_W-1:0] region,
  output logic                   hit,
  output logic [NS-1:0]          sel
);
  xb_route_t rt;

  always_comb begin
    rt  = xb_decode(region);
    hit = rt.hit;
    sel = '0;
    if (rt.hit) sel[rt.idx] = 1'b1;
  end
endmodule

// File: rtl/xbar_slave_arb.sv
module xbar_slave_arb #(
  parameter int NM = 4,
  parameter int PW = 2,
  localparam int IW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fixed_mode,
  input  logic [NM*PW-1:0] prio,
  input  logic [NM-1:0]    req,
  input  logic [NM-1:0]    last,
  input  logic             s_ready,
  output logic [NM-1:0]    gnt,
  output logic             locked
);
  logic [IW-1:0] owner, last_id, pick, gnt_idx, nxt_id;
  logic          gnt_any, new_grant, xfer_end;

  function automatic logic [IW-1:0] rr_pick(input logic [NM-1:0] r,
                                            input logic [IW-1:0] from);
    logic [IW-1:0] res;
    logic          found;
    res   = from;
    found = 1'b0;
    for (int k = 1; k <= NM; k++) begin
      int idx;
      idx = (int'(from) + k) % NM;
      if (!found && r[idx]) begin
        res   = IW'(idx);
        found = 1'b1;
      end
    end
    return res;
  endfunction

  function automatic logic [IW-1:0] fixed_pick(input logic [NM-1:0]    r,
                                               input logic [NM*PW-1:0] p);
    logic [IW-1:0] res;
    logic [PW-1:0] best;
    logic          found;
    res   = '0;
    best  = '0;
    found = 1'b0;
    for (int i = 0; i < NM; i++) begin
      if (r[i] && (!found || p[i*PW +: PW] > best)) begin
        res   = IW'(i);
        best  = p[i*PW +: PW];
        found = 1'b1;
      end
    end
    return res;
  endfunction

  always_comb begin
    pick      = fixed_mode ? fixed_pick(req, prio) : rr_pick(req, last_id);
    gnt_idx   = locked ? owner : pick;
    gnt_any   = locked || (|req);
    new_grant = !locked && (|req);
    gnt       = '0;
    if (gnt_any) gnt[gnt_idx] = 1'b1;
    xfer_end  = gnt_any && req[gnt_idx] && s_ready && last[gnt_idx];
    nxt_id    = IW'((int'(last_id) + 1) % NM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked  <= 1'b0;
      owner   <= '0;
      last_id <= IW'(NM - 1);
    end else begin
      if (new_grant) last_id <= pick;
      if (xfer_end) begin
        locked <= 1'b0;
      end else if (new_grant) begin
        locked <= 1'b1;
        owner  <= pick;
      end
    end
  end

  // R4
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R5
  owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !xfer_end) |=> (locked && gnt == $past(gnt)));

  // R5
  lock_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (new_grant && !xfer_end) |=> locked);

  // R6
  rr_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fixed_mode && new_grant && req[nxt_id]) |-> gnt[nxt_id]);
endmodule

// File: rtl/xbar_switch.sv
module xbar_switch
  import xbar_pkg::*;
#(
  parameter int NM = 4,
  parameter int NS = 5,
  parameter int AW = 32,
  parameter int DW = 64,
  parameter int NDW = 32,
  parameter int PW = 2,
  parameter logic [NS-1:0] NARROW = 5'b11000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_fixed,
  input  logic [NM*PW-1:0] cfg_prio,
  input  logic [NM-1:0]    m_valid,
  output logic [NM-1:0]    m_ready,
  input  logic [NM*AW-1:0] m_addr,
  input  logic [NM-1:0]    m_write,
  input  logic [NM*DW-1:0] m_wdata,
  input  logic [NM-1:0]    m_last,
  output logic [NM*DW-1:0] m_rdata,
  output logic [NM-1:0]    m_err,
  output logic [NS-1:0]    s_valid,
  input  logic [NS-1:0]    s_ready,
  output logic [NS*AW-1:0] s_addr,
  output logic [NS-1:0]    s_write,
  output logic [NS*DW-1:0] s_wdata,
  output logic [NS-1:0]    s_last,
  input  logic [NS*DW-1:0] s_rdata
);
  localparam logic [DW-1:0] NMASK = DW'({NDW{1'b1}});

  logic [NM-1:0] hit;
  logic [NS-1:0] sel  [NM];
  logic [NM-1:0] req  [NS];
  logic [NM-1:0] gnt  [NS];
  logic [NS-1:0] busy;

  function automatic logic [DW-1:0] fit(input logic [DW-1:0] d, input logic narrow);
    return narrow ? (d & NMASK) : d;
  endfunction

  for (genvar gm = 0; gm < NM; gm++) begin : g_dec
    xbar_addr_dec #(.NS(NS)) u_dec (
      .region (m_addr[gm*AW + AW - XB_REGION_W +: XB_REGION_W]),
      .hit    (hit[gm]),
      .sel    (sel[gm])
    );
  end

  always_comb begin
    for (int s = 0; s < NS; s++)
      for (int m = 0; m < NM; m++)
        req[s][m] = m_valid[m] & hit[m] & sel[m][s];
  end

  for (genvar gs = 0; gs < NS; gs++) begin : g_arb
    xbar_slave_arb #(.NM(NM), .PW(PW)) u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .fixed_mode (cfg_fixed),
      .prio       (cfg_prio),
      .req        (req[gs]),
      .last       (m_last),
      .s_ready    (s_ready[gs]),
      .gnt        (gnt[gs]),
      .locked     (busy[gs])
    );
  end

  // slave side: OR-mux of the granted master
  always_comb begin
    s_valid = '0;
    s_addr  = '0;
    s_write = '0;
    s_wdata = '0;
    s_last  = '0;
    for (int s = 0; s < NS; s++) begin
      for (int m = 0; m < NM; m++) begin
        if (gnt[s][m] && req[s][m]) begin
          s_valid[s]          = 1'b1;
          s_addr[s*AW +: AW]  = m_addr[m*AW +: AW];
          s_write[s]          = m_write[m];
          s_wdata[s*DW +: DW] = fit(m_wdata[m*DW +: DW], NARROW[s]);
          s_last[s]           = m_last[m];
        end
      end
    end
  end

  // master side: handshake and read data back along the owned path
  always_comb begin
    m_ready = '0;
    m_err   = '0;
    m_rdata = '0;
    for (int m = 0; m < NM; m++) begin
      if (m_valid[m] && !hit[m]) begin
        m_ready[m] = 1'b1;
        m_err[m]   = 1'b1;
      end
      for (int s = 0; s < NS; s++) begin
        if (gnt[s][m] && req[s][m]) begin
          m_ready[m]          = s_ready[s];
          m_rdata[m*DW +: DW] = fit(s_rdata[s*DW +: DW], NARROW[s]);
        end
      end
    end
  end

  for (genvar gm = 0; gm < NM; gm++) begin : g_mchk
    // R2
    unmapped_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid[gm] && !hit[gm]) |-> (m_ready[gm] && m_err[gm]));
  end

  for (genvar gs = 0; gs < NS; gs++) begin : g_schk
    // R9
    idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|req[gs]) && !busy[gs]) |-> s_valid[gs]);
    // R10
    no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s_valid[gs] |-> (|m_valid));
  end
endmodule

// File: tb/tb_xbar_switch.sv
module tb_xbar_switch;
  localparam int CLK_P = 10;
  localparam int NM = 4, NS = 5, AW = 32, DW = 64;

  logic             clk = 1'b0, rst_n = 1'b0, cfg_fixed = 1'b0;
  logic [7:0]       cfg_prio = '0;
  logic [NM-1:0]    m_valid = '0, m_write = '0, m_last = '0;
  logic [NM*AW-1:0] m_addr = '0;
  logic [NM*DW-1:0] m_wdata = '0;
  logic [NS-1:0]    s_ready = '1;
  logic [NS*DW-1:0] s_rdata;
  logic [NM-1:0]    m_ready, m_err;
  logic [NM*DW-1:0] m_rdata;
  logic [NS-1:0]    s_valid, s_write, s_last;
  logic [NS*AW-1:0] s_addr;
  logic [NS*DW-1:0] s_wdata;

  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  always_comb
    for (int s = 0; s < NS; s++)
      s_rdata[s*DW +: DW] = {32'hCAFE_0000 | 32'(s), 32'h5500_0000 | 32'(s)};

  xbar_switch dut (
    .clk(clk), .rst_n(rst_n), .cfg_fixed(cfg_fixed), .cfg_prio(cfg_prio),
    .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_write(m_write),
    .m_wdata(m_wdata), .m_last(m_last), .m_rdata(m_rdata), .m_err(m_err),
    .s_valid(s_valid), .s_ready(s_ready), .s_addr(s_addr), .s_write(s_write),
    .s_wdata(s_wdata), .s_last(s_last), .s_rdata(s_rdata)
  );

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  // move to next negedge, then settle before sampling
  task automatic step();
    @(negedge clk);
  endtask

  task automatic settle();
    #2;
  endtask

  task automatic drv(input int m, input logic v, input logic [31:0] a,
                     input logic l);
    m_valid[m]          = v;
    m_addr[m*AW +: AW]  = a;
    m_last[m]           = l;
    m_wdata[m*DW +: DW] = {32'hDEAD_BEEF, 32'h1234_5670 | 32'(m)};
    m_write[m]          = m[0];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; m_valid = '0; m_last = '0; s_ready = '1;
    cfg_fixed = 1'b0; cfg_prio = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    settle();
    chk("R10 s_valid", 64'(s_valid), 64'd0);
    chk("R10 m_ready", 64'(m_ready), 64'd0);
  endtask

  task automatic t_decode();
    logic [31:0] base [NS];
    base[0] = 32'h0000_0100; base[1] = 32'h2000_0100; base[2] = 32'h4000_0100;
    base[3] = 32'hC000_0100; base[4] = 32'hF000_0100;
    do_reset();
    for (int s = 0; s < NS; s++) begin
      logic [63:0] rd, wd;
      drv(1, 1'b1, base[s], 1'b1);
      settle();
      rd = {32'hCAFE_0000 | 32'(s), 32'h5500_0000 | 32'(s)};
      wd = {32'hDEAD_BEEF, 32'h1234_5671};
      if (s >= 3) begin rd[63:32] = '0; wd[63:32] = '0; end
      chk("R1 route", 64'(s_valid), 64'(1) << s);
      chk("R1 addr", 64'(s_addr[s*AW +: AW]), 64'(base[s]));
      chk("R1 write", 64'(s_write[s]), 64'd1);
      chk("R9 ready", 64'(m_ready), 64'b0010);
      chk("R8 wdata", s_wdata[s*DW +: DW], wd);
      chk("R8 rdata", m_rdata[1*DW +: DW], rd);
      step();
    end
    drv(1, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic t_unmapped();
    do_reset();
    drv(2, 1'b1, 32'h1000_0040, 1'b1);
    settle();
    chk("R2 ready", 64'(m_ready[2]), 64'd1);
    chk("R2 err", 64'(m_err[2]), 64'd1);
    chk("R2 no slave", 64'(s_valid), 64'd0);
    step();
    drv(2, 1'b1, 32'h8000_0040, 1'b1);
    settle();
    chk("R2 err 8", 64'(m_err), 64'b0100);
    chk("R2 no slave 8", 64'(s_valid), 64'd0);
    step();
    drv(2, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic t_parallel();
    do_reset();
    drv(0, 1'b1, 32'h0000_0008, 1'b1);
    drv(1, 1'b1, 32'h4000_0008, 1'b1);
    drv(2, 1'b1, 32'hC000_0008, 1'b1);
    drv(3, 1'b1, 32'h2000_0008, 1'b1);
    settle();
    chk("R3 s_valid", 64'(s_valid), 64'b01111);
    chk("R3 m_ready", 64'(m_ready), 64'b1111);
    chk("R3 bridge addr", 64'(s_addr[3*AW +: AW]), 64'h0000_0000_C000_0008);
    step();
    m_valid = '0;
  endtask

  task automatic t_roundrobin();
    do_reset();
    for (int m = 0; m < NM; m++) drv(m, 1'b1, 32'h0000_0200 + 32'(m), 1'b1);
    for (int k = 0; k < 6; k++) begin
      settle();
      chk("R6 rr grant", 64'(m_ready), 64'(1) << (k % NM));
      chk("R4 one addr", 64'(s_addr[0 +: AW]), 64'(32'h0000_0200 + 32'(k % NM)));
      step();
    end
    // drop master 2; from last=1 the search skips to 3
    drv(2, 1'b0, 32'h0, 1'b0);
    settle();
    chk("R6 rr skip", 64'(m_ready), 64'b1000);
    step();
    m_valid = '0;
  endtask

  task automatic t_lock();
    do_reset();
    drv(1, 1'b1, 32'h4000_0010, 1'b0);
    settle();
    chk("R5 first beat", 64'(m_ready), 64'b0010);
    step();
    drv(0, 1'b1, 32'h4000_0020, 1'b1);
    drv(1, 1'b1, 32'h4000_0014, 1'b0);
    settle();
    chk("R4 rival stalled", 64'(m_ready), 64'b0010);
    chk("R5 owner addr", 64'(s_addr[2*AW +: AW]), 64'h4000_0014);
    step();
    s_ready[2] = 1'b0;
    drv(1, 1'b1, 32'h4000_0018, 1'b1);
    settle();
    chk("R5 slave stall", 64'(m_ready), 64'b0000);
    chk("R5 owner kept", 64'(s_addr[2*AW +: AW]), 64'h4000_0018);
    step();
    s_ready[2] = 1'b1;
    settle();
    chk("R5 last beat", 64'(m_ready), 64'b0010);
    chk("R5 last flag", 64'(s_last[2]), 64'd1);
    step();
    drv(1, 1'b0, 32'h0, 1'b0);
    settle();
    chk("R5 handover", 64'(m_ready), 64'b0001);
    chk("R5 new addr", 64'(s_addr[2*AW +: AW]), 64'h4000_0020);
    step();
    m_valid = '0;
  endtask

  task automatic t_fixed();
    do_reset();
    cfg_fixed = 1'b1;
    cfg_prio  = 8'b11_11_00_01;
    for (int m = 0; m < NM; m++) drv(m, 1'b1, 32'h4000_0300 + 32'(m), 1'b1);
    settle();
    chk("R7 top tie", 64'(m_ready), 64'b0100);
    step();
    settle();
    chk("R7 stays top", 64'(m_ready), 64'b0100);
    step();
    drv(2, 1'b0, 32'h0, 1'b0);
    settle();
    chk("R7 next top", 64'(m_ready), 64'b1000);
    step();
    drv(3, 1'b0, 32'h0, 1'b0);
    settle();
    chk("R7 prio1 over 0", 64'(m_ready), 64'b0001);
    step();
    drv(0, 1'b0, 32'h0, 1'b0);
    settle();
    chk("R7 lowest", 64'(m_ready), 64'b0010);
    step();
    m_valid = '0;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_decode();
    t_unmapped();
    t_parallel();
    t_roundrobin();
    t_lock();
    t_fixed();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule